// File: doc/BRIEF.md
# Single-Wire Bus Master Sequencer

This block acts as the master of one open-drain single-wire bus. The host gives it one of two commands. The first is a bus reset, in which the line is held low for a long interval and then released while the block listens for a device answering. The second is a byte write, in which eight time slots go out, least significant bit first, one bit per slot. Each slot begins with a low pulse. A short pulse encodes a one and a full-slot pulse encodes a zero, and every slot is followed by a released recovery gap.

All bus timing is counted in microseconds. A divider derives a one-microsecond tick from the system clock, so every interval lasts exactly `<microseconds> × CLK_PER_US` clock cycles. The block has a single output to the bus, a pull-down enable, and never drives the line high. The host watches `busy`, a one-cycle `done` pulse, and a `presence` flag that holds the result of the last reset.

Top module: `onewire_master`

## Requirements
- R1: After `rst_n` is released, `line_pull_low`, `busy`, `done` and `presence` are all 0.
- R2: A command with `cmd_write`=0 (bus reset) holds `line_pull_low` at 1 for RST_LOW_US (default 480) microseconds, which is RST_LOW_US×CLK_PER_US cycles.
- R3: After the reset low pulse, the line stays released for RST_RX_US (default 480) microseconds with `busy` at 1. No slot starts during this time.
- R4: `presence` is loaded once per reset, from the line level PRES_SAMPLE_US (default 70) microseconds after release. A low line gives 1 and a high line gives 0. Byte writes leave `presence` unchanged.
- R5: A command with `cmd_write`=1 sends the eight bits of `cmd_byte` as eight slots, with bit 0 first.
- R6: A one bit pulls the line low for W1_LOW_US (default 6) microseconds and then releases it for the rest of the slot.
- R7: A zero bit pulls the line low for the whole slot of SLOT_US (default 65) microseconds.
- R8: Each slot, including the last, is followed by REC_US (default 5) microseconds with the line released. A slot plus its recovery therefore takes SLOT_US+REC_US microseconds.
- R9: `done` is 1 for exactly one clock, in the first cycle that `busy` is 0 after a command completes.
- R10: `cmd_valid` is ignored while `busy` is 1. The running operation's pulse widths and length are unchanged.
- R11: `line_pull_low` is never 1 while `busy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Start a command (taken only when idle) |
| cmd_write | input | 1 | 0 = bus reset, 1 = byte write |
| cmd_byte | input | DATA_W | Byte to send, bit 0 first |
| line_in | input | 1 | Sensed bus level (asynchronous) |
| line_pull_low | output | 1 | Open-drain enable: 1 pulls the bus low |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle pulse when a command completes |
| presence | output | 1 | A device answered the last reset |

## Verification
Pulse widths and gaps are measured in clock cycles and compared with microsecond counts times the divider ratio. This exposes an off-by-one tick, a slot that does not restart the divider, or a recovery gap that is missing after the last bit. Bytes of all zeros, all ones, alternating bits and random values show whether a design sends the bits in the wrong order or swaps the short and long pulses. The device model answers resets with early, short or missing presence pulses, which catches a sample taken at the wrong moment or a flag that byte writes clobber. Commands injected mid-operation reveal a design that restarts or stretches its sequence when it should ignore them.

// File: rtl/onewire_pkg.sv
package onewire_pkg;

  typedef enum logic [2:0] {
    OW_IDLE,
    OW_RST_LOW,
    OW_RST_LISTEN,
    OW_SLOT,
    OW_RECOVER
  } ow_state_e;

  function automatic int unsigned max_of2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // Bits needed to hold the value v (at least one).
  function automatic int unsigned bits_for(int unsigned v);
    return (v < 2) ? 1 : $clog2(v + 1);
  endfunction

  // Whether a slot pulls the line low at the given microsecond of the slot.
  function automatic logic slot_drives_low(logic bit_val, int unsigned us_now,
                                           int unsigned w1_us);
    return !bit_val || (us_now < w1_us);
  endfunction

  // Length of the phase held in a state, in microseconds.
  function automatic int unsigned phase_len_us(ow_state_e st, int unsigned rl,
                                               int unsigned rx, int unsigned sl,
                                               int unsigned rc);
    case (st)
      OW_RST_LOW:    return rl;
      OW_RST_LISTEN: return rx;
      OW_RECOVER:    return rc;
      default:       return sl;
    endcase
  endfunction

endpackage

// File: rtl/onewire_tick_gen.sv
module onewire_tick_gen #(
  parameter int unsigned CLK_PER_US = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic tick,
  output logic us_first
);
  localparam int unsigned CW = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
  localparam logic [CW-1:0] LAST = CW'(CLK_PER_US - 1);

  logic [CW-1:0] cnt;

  assign tick     = (cnt == LAST);
  assign us_first = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt <= '0;
    else if (restart || tick) cnt <= '0;
    else                     cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/onewire_us_timer.sv
module onewire_us_timer #(
  parameter int unsigned UW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          tick,
  input  logic [UW-1:0] len,
  output logic [UW-1:0] us_now,
  output logic          expire
);
  assign expire = tick && (us_now == (len - 1'b1));

  always_ff @(posedge clk) begin
    if (!rst_n)       us_now <= '0;
    else if (restart) us_now <= '0;
    else if (tick)    us_now <= us_now + 1'b1;
  end
endmodule

// File: rtl/onewire_line_sync.sv
module onewire_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_raw,
  output logic line_q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (!rst_n) chain <= 1'b1;
        else        chain <= line_raw;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], line_raw};
      end
    end
  endgenerate

  assign line_q = chain[STAGES-1];
endmodule

// File: rtl/onewire_bit_shifter.sv
module onewire_bit_shifter #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] data,
  input  logic          advance,
  output logic          cur_bit,
  output logic          last_bit
);
  localparam int unsigned IW = (DW > 1) ? $clog2(DW) : 1;

  logic [DW-1:0] sreg;
  logic [IW-1:0] idx;

  assign cur_bit  = sreg[0];
  assign last_bit = (idx == IW'(DW - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sreg <= '0;
      idx  <= '0;
    end else if (load) begin
      sreg <= data;
      idx  <= '0;
    end else if (advance) begin
      sreg <= sreg >> 1;
      idx  <= idx + 1'b1;
    end
  end
endmodule

// File: rtl/onewire_seq_fsm.sv
module onewire_seq_fsm
  import onewire_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      accept,
  input  logic      cmd_write,
  input  logic      expire,
  input  logic      last_bit,
  output ow_state_e state,
  output logic      advance,
  output logic      done_evt
);
  ow_state_e nxt;

  always_comb begin
    nxt      = state;
    advance  = 1'b0;
    done_evt = 1'b0;
    case (state)
      OW_IDLE:
        if (accept) nxt = cmd_write ? OW_SLOT : OW_RST_LOW;
      OW_RST_LOW:
        if (expire) nxt = OW_RST_LISTEN;
      OW_RST_LISTEN:
        if (expire) begin
          nxt      = OW_IDLE;
          done_evt = 1'b1;
        end
      OW_SLOT:
        if (expire) nxt = OW_RECOVER;
      OW_RECOVER:
        if (expire) begin
          if (last_bit) begin
            nxt      = OW_IDLE;
            done_evt = 1'b1;
          end else begin
            nxt     = OW_SLOT;
            advance = 1'b1;
          end
        end
      default: nxt = OW_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= OW_IDLE;
    else        state <= nxt;
  end
endmodule

// File: rtl/onewire_master.sv
module onewire_master
  import onewire_pkg::*;
#(
  parameter int unsigned CLK_PER_US     = 100,
  parameter int unsigned DATA_W         = 8,
  parameter int unsigned RST_LOW_US     = 480,
  parameter int unsigned RST_RX_US      = 480,
  parameter int unsigned PRES_SAMPLE_US = 70,
  parameter int unsigned W1_LOW_US      = 6,
  parameter int unsigned SLOT_US        = 65,
  parameter int unsigned REC_US         = 5,
  parameter int unsigned SYNC_STAGES    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic              cmd_write,
  input  logic [DATA_W-1:0] cmd_byte,
  input  logic              line_in,
  output logic              line_pull_low,
  output logic              busy,
  output logic              done,
  output logic              presence
);
  localparam int unsigned MAX_US = max_of2(max_of2(RST_LOW_US, RST_RX_US),
                                           max_of2(SLOT_US, REC_US));
  localparam int unsigned UW = bits_for(MAX_US);

  // Named internal events
  ow_state_e     state;
  logic          accept;
  logic          restart;
  logic          tick;
  logic          us_first;
  logic [UW-1:0] us_now;
  logic [UW-1:0] phase_len;
  logic          expire;
  logic          advance;
  logic          done_evt;
  logic          cur_bit;
  logic          last_bit;
  logic          line_q;
  logic          sample_evt;

  assign accept  = cmd_valid && (state == OW_IDLE);
  assign restart = accept || expire;
  assign phase_len = UW'(phase_len_us(state, RST_LOW_US, RST_RX_US, SLOT_US, REC_US));

  onewire_tick_gen #(.CLK_PER_US(CLK_PER_US)) u_tick (
    .clk(clk), .rst_n(rst_n), .restart(restart), .tick(tick), .us_first(us_first)
  );

  onewire_us_timer #(.UW(UW)) u_timer (
    .clk(clk), .rst_n(rst_n), .restart(restart), .tick(tick),
    .len(phase_len), .us_now(us_now), .expire(expire)
  );

  onewire_bit_shifter #(.DW(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(accept), .data(cmd_byte),
    .advance(advance), .cur_bit(cur_bit), .last_bit(last_bit)
  );

  onewire_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .line_raw(line_in), .line_q(line_q)
  );

  onewire_seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .accept(accept), .cmd_write(cmd_write),
    .expire(expire), .last_bit(last_bit), .state(state),
    .advance(advance), .done_evt(done_evt)
  );

  assign sample_evt = (state == OW_RST_LISTEN) && us_first &&
                      (us_now == UW'(PRES_SAMPLE_US));

  always_comb begin
    case (state)
      OW_RST_LOW: line_pull_low = 1'b1;
      OW_SLOT:    line_pull_low = slot_drives_low(cur_bit, 32'(us_now), W1_LOW_US);
      default:    line_pull_low = 1'b0;
    endcase
  end

  assign busy = (state != OW_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done     <= 1'b0;
      presence <= 1'b0;
    end else begin
      done <= done_evt;
      if (sample_evt) presence <= !line_q;
    end
  end
endmodule

// File: rtl/onewire_master_chk.sv
module onewire_master_chk #(
  parameter int unsigned MAX_LOW_CYC = 48000
) (
  input logic clk,
  input logic rst_n,
  input logic cmd_valid,
  input logic line_pull_low,
  input logic busy,
  input logic done,
  input logic presence,
  input logic sample_evt
);
  logic [31:0] low_run;

  always_ff @(posedge clk) begin
    if (!rst_n)             low_run <= '0;
    else if (line_pull_low) low_run <= low_run + 1;
    else                    low_run <= '0;
  end

  // R11: bus only pulled while an operation runs
  a_r11_release_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !line_pull_low);

  // R9: done is a single-cycle pulse
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9: done coincides with the end of busy
  a_r9_done_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R10: an operation only starts from a command seen while idle
  a_r10_start_needs_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cmd_valid));

  // R4: presence changes only at its sample point
  a_r4_presence_at_sample: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(presence) |-> $past(sample_evt));

  // R2: no low pulse outlasts the longest programmed interval
  a_r2_low_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    low_run <= MAX_LOW_CYC);
endmodule

bind onewire_master onewire_master_chk #(
  .MAX_LOW_CYC((RST_LOW_US > SLOT_US ? RST_LOW_US : SLOT_US) * CLK_PER_US)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .line_pull_low(line_pull_low),
  .busy(busy), .done(done), .presence(presence), .sample_evt(sample_evt)
);

// File: tb/onewire_master_test.sv
module onewire_master_test;
  localparam int CPU = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic       cmd_write = 1'b0;
  logic [7:0] cmd_byte = 8'h00;
  logic       line_pull_low, busy, done, presence;
  logic       dev_low = 1'b0;
  wire        line_in = !(line_pull_low || dev_low);

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit finished = 1'b0;

  // device model settings, in microseconds
  int  dev_delay = 15;
  int  dev_width = 100;
  bit  dev_on    = 1'b0;
  int  low_run   = 0;
  int  rel       = 0;
  bit  armed     = 1'b0;

  always #5 clk = ~clk;

  onewire_master #(.CLK_PER_US(CPU)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
    .cmd_byte(cmd_byte), .line_in(line_in), .line_pull_low(line_pull_low),
    .busy(busy), .done(done), .presence(presence)
  );

  // Device answering long reset pulses
  always @(negedge clk) begin
    cycles++;
    if (line_pull_low) begin
      low_run++;
      armed   = 1'b0;
      dev_low = 1'b0;
    end else begin
      if (low_run >= 400 * CPU && dev_on) begin
        armed = 1'b1;
        rel   = 0;
      end
      low_run = 0;
      if (armed) begin
        dev_low = (rel >= dev_delay * CPU) && (rel < (dev_delay + dev_width) * CPU);
        rel++;
        if (rel > 320 * CPU) armed = 1'b0;
      end else begin
        dev_low = 1'b0;
      end
    end
  end

  function automatic int exp_low(bit b);
    return b ? 6 * CPU : 65 * CPU;
  endfunction

  function automatic int exp_gap(bit b);
    return (b ? (65 - 6 + 5) : 5) * CPU;
  endfunction

  function automatic bit exp_presence(bit on, int d, int w);
    return on && (d <= 70) && (d + w > 70);
  endfunction

  task automatic chk(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic do_reset(bit on, int d, int w, bit poke);
    int lw;
    int hw;
    dev_on = on; dev_delay = d; dev_width = w;
    @(negedge clk); cmd_valid = 1'b1; cmd_write = 1'b0;
    @(negedge clk); cmd_valid = 1'b0;
    lw = 0;
    while (line_pull_low) begin
      if (poke && lw == 2) begin cmd_valid = 1'b1; cmd_write = 1'b1; end
      else cmd_valid = 1'b0;
      lw++;
      @(negedge clk);
    end
    cmd_valid = 1'b0;
    chk(lw == 480 * CPU, poke ? "R10/R2 reset low width" : "R2 reset low width",
        lw, 480 * CPU);
    hw = 0;
    while (!line_pull_low && busy) begin hw++; @(negedge clk); end
    chk(hw == 480 * CPU, "R3 listen window", hw, 480 * CPU);
    chk(done == 1'b1 && busy == 1'b0, "R9 done at end of reset", done, 1);
    chk(presence == exp_presence(on, d, w), "R4 presence", presence,
        exp_presence(on, d, w));
    @(negedge clk);
    chk(done == 1'b0, "R9 done one cycle", done, 0);
  endtask

  task automatic do_byte(logic [7:0] d, bit poke);
    int  lw;
    int  gw;
    bit  pres_before;
    pres_before = presence;
    @(negedge clk); cmd_valid = 1'b1; cmd_write = 1'b1; cmd_byte = d;
    @(negedge clk); cmd_valid = 1'b0;
    for (int i = 0; i < 8; i++) begin
      lw = 0;
      while (line_pull_low) begin
        if (poke && i == 0 && lw == 2) begin cmd_valid = 1'b1; cmd_write = 1'b0; end
        else cmd_valid = 1'b0;
        lw++;
        @(negedge clk);
      end
      cmd_valid = 1'b0;
      if (d[i]) chk(lw == exp_low(1'b1), "R6 write-1 low width (R5 order)", lw, exp_low(1'b1));
      else      chk(lw == exp_low(1'b0), "R7 write-0 low width (R5 order)", lw, exp_low(1'b0));
      gw = 0;
      while (!line_pull_low && busy) begin gw++; @(negedge clk); end
      chk(gw == exp_gap(d[i]), poke ? "R10/R8 slot gap" : "R8 slot gap", gw, exp_gap(d[i]));
      if (i < 7) chk(busy == 1'b1, "R5 busy until eighth slot", busy, 1);
    end
    chk(done == 1'b1 && busy == 1'b0, "R9 done at end of byte", done, 1);
    chk(presence == pres_before, "R4 presence held over write", presence, pres_before);
    @(negedge clk);
    chk(done == 1'b0, "R9 done one cycle", done, 0);
    chk(line_pull_low == 1'b0, "R11 released when idle", line_pull_low, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(line_pull_low == 1'b0, "R1 pull_low", line_pull_low, 0);
    chk(busy == 1'b0, "R1 busy", busy, 0);
    chk(done == 1'b0, "R1 done", done, 0);
    chk(presence == 1'b0, "R1 presence", presence, 0);

    // directed corners
    do_reset(1'b1, 15, 60, 1'b0);
    do_byte(8'h00, 1'b0);
    do_byte(8'hFF, 1'b1);
    do_reset(1'b0, 15, 60, 1'b0);
    do_byte(8'hA5, 1'b0);
    do_reset(1'b1, 20, 40, 1'b1);
    do_reset(1'b1, 60, 240, 1'b0);

    // constrained random
    void'($urandom(32'd1234));
    for (int k = 0; k < 6; k++) begin
      do_byte(8'($urandom), bit'($urandom % 2));
    end
    for (int k = 0; k < 3; k++) begin
      do_reset(1'b1, 15 + int'($urandom % 46), 60 + int'($urandom % 181),
               bit'($urandom % 2));
    end

    finished = 1'b1;
    report();
  end

  initial begin
    wait (cycles > 190000);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
      report();
    end
  end
endmodule